// File: doc/BRIEF.md
# Multi-Frame SPI ADC Burst Sequencer

This block is an SPI master that runs a whole burst of ADC conversion frames once software has started it. Through a small synchronous register port, software programs the frame length and how many bits go out and come in per frame. It also sets the serial clock divider, the number of frames, the idle gap between frames and a transmit word. A write with the top bit of the command register set then starts the burst. The engine drives chip select, the serial clock and the output line, samples the input line and stores each received frame in a result slot. The slots read back as 64-bit words, four frames per word.

A busy bit in a status register stays set from the start until the last frame ends. Software polls it and then fetches the packed results. The configuration is copied when a burst starts, so software may prepare the next burst while the current one runs.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock and output line are low, the status busy bit reads 0 and every result word reads 0.
- R2: A write to the command register (address 4) with bit 63 set starts a burst when idle; a command write with bit 63 clear starts nothing.
- R3: The serial clock is low at idle and within a frame spends (divider+1) system clocks low, then (divider+1) high, per bit (SPI mode 0); the output line changes only while the clock is low, and the input line is sampled when the clock rises.
- R4: Each frame has (length field + 1) clock pulses, and chip select stays low for the whole frame, i.e. 2*(divider+1)*(length field+1) system clocks.
- R5: A burst runs (frame-count field + 1) frames.
- R6: Between frames, chip select is high for (gap field + 1) system clocks; after the last frame, chip select rises and the burst ends with no gap.
- R7: In each frame, bit k (0 = first) on the output line is bit (15-k) of the transmit word when k is below the output-count field, else 0.
- R8: The first min(input count, frame length) sampled bits of a frame form its result, first bit most significant, right-aligned in a 16-bit slot.
- R9: Frame f goes to result word f/4 (addresses 8 to 11), with slot f%4 = 0 at bits 63:48 down to slot 3 at bits 15:0; frames 16 and later are dropped, and all slots clear when a burst starts.
- R10: Status register (address 5) bit 0 reads 1 while a burst runs and 0 otherwise.
- R11: A start written while busy is ignored, and configuration written during a burst does not change that burst; it applies from the next start.
- R12: Configuration registers read back their fields one clock after the address is presented: address 0 = length field [3:0], output count [12:8], input count [20:16]; address 1 = divider [7:0], frame-count field [20:16]; address 2 = gap [15:0]; address 3 = transmit word [15:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write enable for the register port |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after the address |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the ADC |
| spi_miso | input | 1 | Serial data from the ADC |

## Verification
The assertions check on every cycle the pin rules that need no knowledge of the test: the clock stays low whenever chip select is high, the output line holds steady while the clock is high, and the burst ends with the pins at rest. They also check that the frame counter never passes the programmed count, that at most one slot is written per cycle and that a start clears the slots. Exact half-period lengths, gap lengths, bit order on the output line, slot placement, dropping of excess frames and the ignored mid-burst start can only be shown by the bench scenarios. In those scenarios a behavioural pin model and a model ADC are compared against the block on every clock.

// File: rtl/adc_burst_pkg.sv
`timescale 1ns/1ps
package adc_burst_pkg;
  localparam int FRAME_W = 16;
  localparam int LEN_W   = $clog2(FRAME_W);
  localparam int BIT_W   = $clog2(FRAME_W) + 1;
  localparam int DIV_W   = 8;
  localparam int FCNT_W  = 5;
  localparam int GAP_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 64;
  localparam int SLOTS_PER_WORD = DATA_W / FRAME_W;

  localparam int A_FRAME  = 0;
  localparam int A_SEQ    = 1;
  localparam int A_GAP    = 2;
  localparam int A_TX     = 3;
  localparam int A_CMD    = 4;
  localparam int A_STATUS = 5;
  localparam int A_RD0    = 8;

  localparam int OFS_OUT  = 8;
  localparam int OFS_IN   = 16;
  localparam int OFS_FCNT = 16;

  typedef struct packed {
    logic [LEN_W-1:0]   len_m1;
    logic [BIT_W-1:0]   out_cnt;
    logic [BIT_W-1:0]   in_cnt;
    logic [DIV_W-1:0]   div;
    logic [FCNT_W-1:0]  frames_m1;
    logic [GAP_W-1:0]   gap;
    logic [FRAME_W-1:0] tx;
  } seq_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} eng_state_t;
endpackage

// File: rtl/adc_burst_regs.sv
`timescale 1ns/1ps
module adc_burst_regs
  import adc_burst_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          we,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          busy,
  input  logic [NUM_WORDS*DATA_W-1:0]   words,
  output seq_cfg_t                      cfg,
  output logic                          start,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] rd_next;

  assign start = we && (addr == ADDR_W'(A_CMD)) && wdata[DATA_W-1] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.len_m1    <= LEN_W'(FRAME_W - 1);
      cfg.out_cnt   <= '0;
      cfg.in_cnt    <= BIT_W'(FRAME_W);
      cfg.div       <= DIV_W'(36);
      cfg.frames_m1 <= FCNT_W'(15);
      cfg.gap       <= '0;
      cfg.tx        <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(A_FRAME)) begin
        cfg.len_m1  <= wdata[LEN_W-1:0];
        cfg.out_cnt <= wdata[OFS_OUT +: BIT_W];
        cfg.in_cnt  <= wdata[OFS_IN +: BIT_W];
      end
      if (addr == ADDR_W'(A_SEQ)) begin
        cfg.div       <= wdata[DIV_W-1:0];
        cfg.frames_m1 <= wdata[OFS_FCNT +: FCNT_W];
      end
      if (addr == ADDR_W'(A_GAP)) cfg.gap <= wdata[GAP_W-1:0];
      if (addr == ADDR_W'(A_TX))  cfg.tx  <= wdata[FRAME_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(A_FRAME)) begin
      rd_next[LEN_W-1:0]       = cfg.len_m1;
      rd_next[OFS_OUT +: BIT_W] = cfg.out_cnt;
      rd_next[OFS_IN +: BIT_W]  = cfg.in_cnt;
    end
    if (addr == ADDR_W'(A_SEQ)) begin
      rd_next[DIV_W-1:0]          = cfg.div;
      rd_next[OFS_FCNT +: FCNT_W] = cfg.frames_m1;
    end
    if (addr == ADDR_W'(A_GAP))    rd_next[GAP_W-1:0]   = cfg.gap;
    if (addr == ADDR_W'(A_TX))     rd_next[FRAME_W-1:0] = cfg.tx;
    if (addr == ADDR_W'(A_STATUS)) rd_next[0]           = busy;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(A_RD0 + w)) rd_next = words[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/adc_burst_engine.sv
`timescale 1ns/1ps
module adc_burst_engine
  import adc_burst_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  seq_cfg_t           cfg,
  input  logic               miso,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               busy,
  output logic               res_we,
  output logic [FCNT_W-1:0]  res_idx,
  output logic [FRAME_W-1:0] res_data
);
  eng_state_t         st;
  seq_cfg_t           run_q;
  logic [GAP_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic [FCNT_W-1:0]  frame_idx;
  logic [FRAME_W-1:0] shreg;
  logic               half_done, last_bit, gap_done, last_frame;

  function automatic logic tx_bit(input seq_cfg_t c, input logic [BIT_W-1:0] k);
    logic [FRAME_W-1:0] s;
    s = c.tx << k;
    return (k < c.out_cnt) ? s[FRAME_W-1] : 1'b0;
  endfunction

  assign half_done  = (cnt == GAP_W'(run_q.div));
  assign last_bit   = (bit_idx == BIT_W'(run_q.len_m1));
  assign gap_done   = (cnt == run_q.gap);
  assign last_frame = (frame_idx == run_q.frames_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      run_q     <= '0;
      cnt       <= '0;
      bit_idx   <= '0;
      frame_idx <= '0;
      shreg     <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      busy      <= 1'b0;
      res_we    <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else begin
      res_we <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            run_q     <= cfg;
            st        <= ST_SHIFT;
            busy      <= 1'b1;
            cs_n      <= 1'b0;
            sclk      <= 1'b0;
            cnt       <= '0;
            bit_idx   <= '0;
            frame_idx <= '0;
            shreg     <= '0;
            mosi      <= tx_bit(cfg, '0);
          end
        end
        ST_SHIFT: begin
          if (!half_done) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              if (bit_idx < run_q.in_cnt) shreg <= {shreg[FRAME_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (!last_bit) begin
                bit_idx <= bit_idx + 1'b1;
                mosi    <= tx_bit(run_q, bit_idx + 1'b1);
              end else begin
                cs_n     <= 1'b1;
                mosi     <= 1'b0;
                res_we   <= 1'b1;
                res_idx  <= frame_idx;
                res_data <= shreg;
                if (last_frame) begin
                  st   <= ST_IDLE;
                  busy <= 1'b0;
                end else begin
                  st <= ST_GAP;
                end
              end
            end
          end
        end
        ST_GAP: begin
          if (!gap_done) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt       <= '0;
            st        <= ST_SHIFT;
            cs_n      <= 1'b0;
            bit_idx   <= '0;
            frame_idx <= frame_idx + 1'b1;
            shreg     <= '0;
            mosi      <= tx_bit(run_q, '0);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: no clock pulse outside a frame
  p_clk_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R3: output line only moves while the clock is low
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk) |-> $stable(mosi));
  // R3: pins at rest whenever no burst runs
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk && !mosi));
  // R6: the burst ends with chip select high
  p_end_deselect_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cs_n && $rose(cs_n)));
  // R5: never more frames than programmed
  p_frame_bound_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (frame_idx <= run_q.frames_m1));
endmodule

// File: rtl/adc_burst_pack.sv
`timescale 1ns/1ps
module adc_burst_pack
  import adc_burst_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        res_we,
  input  logic [FCNT_W-1:0]           res_idx,
  input  logic [FRAME_W-1:0]          res_data,
  output logic [NUM_WORDS*DATA_W-1:0] words
);
  localparam int NSLOT = NUM_WORDS * SLOTS_PER_WORD;

  logic [FRAME_W-1:0] slot_q [NSLOT];
  logic [NSLOT-1:0]   slot_we;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_we[s] = res_we && (res_idx == FCNT_W'(s));
    always_ff @(posedge clk) begin
      if (rst || clr)      slot_q[s] <= '0;
      else if (slot_we[s]) slot_q[s] <= res_data;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar p = 0; p < SLOTS_PER_WORD; p++) begin : g_pos
      assign words[w*DATA_W + (SLOTS_PER_WORD-1-p)*FRAME_W +: FRAME_W] =
        slot_q[w*SLOTS_PER_WORD + p];
    end
  end

  // R9: one slot at most per result
  p_slot_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_we));
  // R9: a start leaves every slot empty
  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (words == '0));
endmodule

// File: rtl/adc_burst_seq.sv
`timescale 1ns/1ps
module adc_burst_seq
  import adc_burst_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  seq_cfg_t                    cfg;
  logic                        start, busy, res_we;
  logic [FCNT_W-1:0]           res_idx;
  logic [FRAME_W-1:0]          res_data;
  logic [NUM_WORDS*DATA_W-1:0] words;

  adc_burst_regs #(.NUM_WORDS(NUM_WORDS)) regs_i (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .busy(busy), .words(words), .cfg(cfg), .start(start), .rdata(reg_rdata)
  );

  adc_burst_engine engine_i (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .miso(spi_miso),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data)
  );

  adc_burst_pack #(.NUM_WORDS(NUM_WORDS)) pack_i (
    .clk(clk), .rst(rst), .clr(start), .res_we(res_we), .res_idx(res_idx),
    .res_data(res_data), .words(words)
  );
endmodule

// File: tb/adc_burst_seq_tb.sv
`timescale 1ns/1ps
module adc_burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_burst_seq dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // shadow of programmed fields
  int sh_len_m1 = 15, sh_out = 0, sh_in = 16, sh_div = 36, sh_fm1 = 15, sh_gap = 0, sh_tx = 0;
  // settings of the burst being modelled
  int run_id = 0, run_len = 0, run_in = 0, run_frames = 0;
  logic [3:0] exp_q[$];   // {busy, cs_n, sclk, mosi}
  bit last_busy = 0;

  function automatic logic [15:0] adc_val(int run, int f);
    return 16'((run * 16'h3B1D) ^ (f * 16'h1A67) ^ 16'hC35A);
  endfunction

  function automatic logic [15:0] capt(int run, int f);
    int n;
    logic [15:0] v;
    n = (run_in < run_len) ? run_in : run_len;
    v = adc_val(run, f);
    if (n == 0) return 16'h0;
    return v >> (16 - n);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // behavioural pin model built at the start edge
  task automatic build_burst();
    int h;
    logic [15:0] tx;
    h  = sh_div + 1;
    tx = 16'(sh_tx);
    run_id++;
    run_len    = sh_len_m1 + 1;
    run_in     = sh_in;
    run_frames = sh_fm1 + 1;
    for (int f = 0; f < run_frames; f++) begin
      for (int k = 0; k < run_len; k++) begin
        logic b;
        b = (k < sh_out) ? tx[15-k] : 1'b0;
        for (int i = 0; i < h; i++) exp_q.push_back({1'b1, 1'b0, 1'b0, b});
        for (int i = 0; i < h; i++) exp_q.push_back({1'b1, 1'b0, 1'b1, b});
      end
      if (f < run_frames - 1)
        for (int i = 0; i <= sh_gap; i++) exp_q.push_back(4'b1100);
    end
  endtask

  // model ADC: one new value per frame, shifted out after each falling clock
  int  afr = 0, abit = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    logic [15:0] v;
    if (rst) begin
      abit = 0;
      spi_miso = 1'b0;
    end else begin
      if (prev_cs && !spi_cs_n) abit = 0;
      else if (!prev_cs && spi_cs_n) afr++;
      else if (!spi_cs_n && prev_sclk && !spi_sclk) abit++;
      v = adc_val(run_id, afr);
      spi_miso = (!spi_cs_n && abit < 16) ? v[15-abit] : 1'b0;
    end
    prev_cs   = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  // every-clock pin comparison (R3 R4 R6 R7)
  always @(negedge clk) begin
    logic [3:0] e;
    if (!rst) begin
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 4'b0100;
      last_busy = e[3];
      chk("R3 R4 R6 R7 pins", {61'b0, spi_cs_n, spi_sclk, spi_mosi}, {61'b0, e[2:0]});
    end
  end

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    reg_addr  = 4'(a);
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    #1;
    if (a == 4 && d[63] && !last_busy) begin
      afr = 0;
      build_burst();
    end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    reg_we   = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_frame(int len_m1, int o, int i);
    sh_len_m1 = len_m1; sh_out = o; sh_in = i;
    wr(0, 64'(len_m1) | (64'(o) << 8) | (64'(i) << 16));
  endtask
  task automatic set_seq(int dv, int fm1);
    sh_div = dv; sh_fm1 = fm1;
    wr(1, 64'(dv) | (64'(fm1) << 16));
  endtask
  task automatic set_gap(int g);  sh_gap = g; wr(2, 64'(g)); endtask
  task automatic set_tx(int t);   sh_tx = t;  wr(3, 64'(t)); endtask
  task automatic go();            wr(4, 64'h8000_0000_0000_0000); endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_results(string tag);
    logic [63:0] got, exp;
    for (int w = 0; w < 4; w++) begin
      exp = '0;
      for (int s = 0; s < 4; s++) begin
        int f;
        f = w * 4 + s;
        if (f < run_frames) exp[(3-s)*16 +: 16] = capt(run_id, f);
      end
      rd(8 + w, got);
      chk(tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R5 burst never finished got=hung exp=idle");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 pins", {61'b0, spi_cs_n, spi_sclk, spi_mosi}, 64'b100);
    rd(5, d); chk("R1 status", d, 64'h0);
    for (int w = 0; w < 4; w++) begin rd(8 + w, d); chk("R1 result word", d, 64'h0); end
    rd(0, d); chk("R12 frame reset", d, 64'h0010_000F);
    rd(1, d); chk("R12 seq reset", d, 64'h000F_0024);

    // R2: command without bit 63 starts nothing
    wr(4, 64'h7FFF_FFFF_FFFF_FFFF);
    repeat (30) @(negedge clk);
    rd(5, d); chk("R2 no start", d, 64'h0);

    // burst 1: full 16-bit input frames
    set_frame(15, 0, 16); set_seq(1, 4); set_gap(3); set_tx(0);
    rd(0, d); chk("R12 frame readback", d, 64'h0010_000F);
    rd(2, d); chk("R12 gap readback", d, 64'h3);
    go();
    rd(5, d); chk("R10 busy during burst", d, 64'h1);
    wait_idle();
    rd(5, d); chk("R10 idle after burst", d, 64'h0);
    check_results("R5 R8 R9 burst1");

    // burst 2: short frames, output word, truncated input
    set_frame(11, 16, 8); set_seq(0, 1); set_gap(0); set_tx(16'hA5C3);
    rd(3, d); chk("R12 tx readback", d, 64'hA5C3);
    go();
    wait_idle();
    check_results("R7 R8 R9 burst2");

    // burst 3: more frames than slots
    set_frame(15, 5, 16); set_seq(0, 19); set_gap(1); set_tx(16'hF0F0);
    go();
    wait_idle();
    check_results("R9 discard burst3");

    // burst 4: start and reconfigure during a burst
    set_frame(7, 3, 10); set_seq(2, 2); set_gap(2); set_tx(16'h8000);
    go();
    repeat (10) @(negedge clk);
    wr(4, 64'h8000_0000_0000_0000);
    set_seq(0, 0);
    rd(5, d); chk("R11 still busy", d, 64'h1);
    wait_idle();
    check_results("R11 burst4 unchanged");
    rd(1, d); chk("R11 R12 new seq readback", d, 64'h0);

    // burst 5: new settings apply, slots cleared
    go();
    wait_idle();
    check_results("R9 R11 burst5 clear");

    done = 1;
    summary();
    $finish;
  end
endmodule